// File: doc/BRIEF.md
# ADC Result and Overrun Flag Tracker

This block sits between a multi-channel analog-to-digital converter and the register bus. Each time the converter finishes, it raises a completion strobe carrying a channel number and a result word. The tracker stores that word in the channel's own result register and in one shared most-recent-result register. It also maintains four kinds of status: a per-channel "fresh result" flag, a global "result pending" flag, a per-channel overrun flag and a global overrun flag.

Software reads through a one-cycle-latency read port. Reading a channel's result register retires that channel's fresh flag. Reading the most-recent-result register retires the global pending flag. Reading the status word reports every flag and then wipes both kinds of overrun flag. The converter also announces the start of each conversion. A channel whose enable drops at any time between that start and the completion loses its result: nothing in the block changes.

Top module: `adc_result_tracker`

## Requirements
- R1: After a synchronous active-high reset, every flag is zero and every result register and the most-recent-result register read back as zero.
- R2: An accepted completion writes its word into the channel's result register (read address = channel number) and into the most-recent-result register (read address NUM_CH).
- R3: An accepted completion sets that channel's fresh flag and the global pending flag.
- R4: Reading a channel's result register clears only that channel's fresh flag. Reading the most-recent-result register clears only the global pending flag.
- R5: An accepted completion for a channel whose fresh flag is already set sets that channel's overrun flag.
- R6: An accepted completion while the global pending flag is set sets the global overrun flag.
- R7: The status word (read address NUM_CH+1) holds the fresh flags in bits [NUM_CH-1:0], the overrun flags in bits [2*NUM_CH-1:NUM_CH], the pending flag in bit 2*NUM_CH and the global overrun flag in bit 2*NUM_CH+1. Reading it returns the flags as they were before the read, clears every overrun flag, and leaves the fresh and pending flags untouched.
- R8: When a clearing read and a setting completion land in the same cycle, the set wins. The read returns the old contents, and the overrun checks use the flag values from before the read.
- R9: A completion is discarded if its channel's enable is low at completion, or was low in any cycle since that channel's last conversion start. A discarded completion changes no register and no flag.
- R10: Read data appears one cycle after the read request. A read of an address above NUM_CH+1 returns zero and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | NUM_CH | Per-channel enable |
| cnv_begin | input | 1 | Conversion start strobe |
| cnv_begin_ch | input | CH_W | Channel of the starting conversion |
| cnv_done | input | 1 | Conversion completion strobe |
| cnv_done_ch | input | CH_W | Channel of the completed conversion |
| cnv_data | input | DATA_W | Completed result word |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | RD_W | Read data, valid one cycle after rd_en |

## Verification
A completion and a flag-clearing read can fall in the same clock cycle. The bench provokes this three times, each with the completion and the read in one cycle:
- a channel read together with a completion on the same channel;
- a status read together with a completion while the pending flag is high;
- a most-recent-result read together with a completion.

In each case the scoreboard requires that the read returns the contents from before the cycle. A following status read must then show the new fresh flag or pending flag still set, and must show the overrun flags that the pre-read flag values imply.

// File: rtl/adc_trk_pkg.sv
package adc_trk_pkg;

    typedef enum logic [1:0] {
        SEL_CHAN = 2'd0,
        SEL_LAST = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;

    function automatic int chan_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adc_trk_gate.sv
module adc_trk_gate #(
    parameter int NUM_CH = 8,
    localparam int CH_W = adc_trk_pkg::chan_bits(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic              cnv_begin,
    input  logic [CH_W-1:0]   cnv_begin_ch,
    input  logic              cnv_done,
    input  logic [CH_W-1:0]   cnv_done_ch,
    output logic              accept
);

    typedef struct packed {
        logic [NUM_CH-1:0] pend;
        logic [NUM_CH-1:0] spoil;
    } gate_t;

    gate_t st_d, st_q;
    logic  acc_d;

    always_comb begin
        st_d  = st_q;
        acc_d = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            // a channel that loses its enable while in flight is marked spoiled
            if (st_q.pend[k] && !chan_en[k]) begin
                st_d.spoil[k] = 1'b1;
            end
            if (cnv_done && cnv_done_ch == CH_W'(k)) begin
                acc_d         = chan_en[k] && !st_q.spoil[k];
                st_d.pend[k]  = 1'b0;
                st_d.spoil[k] = 1'b0;
            end
            if (cnv_begin && cnv_begin_ch == CH_W'(k)) begin
                st_d.pend[k]  = 1'b1;
                st_d.spoil[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept = acc_d;

endmodule

// File: rtl/adc_trk_store.sv
module adc_trk_store #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 10,
    localparam int CH_W = adc_trk_pkg::chan_bits(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     accept,
    input  logic [CH_W-1:0]          ch,
    input  logic [DATA_W-1:0]        word,
    output logic [NUM_CH*DATA_W-1:0] chan_flat,
    output logic [DATA_W-1:0]        last_word
);

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] chan;
        logic [DATA_W-1:0]             last;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.last = word;
            for (int k = 0; k < NUM_CH; k++) begin
                if (ch == CH_W'(k)) begin
                    st_d.chan[k] = word;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_flat = st_q.chan;
    assign last_word = st_q.last;

endmodule

// File: rtl/adc_trk_flags.sv
module adc_trk_flags #(
    parameter int NUM_CH = 8,
    localparam int CH_W = adc_trk_pkg::chan_bits(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [CH_W-1:0]   ch,
    input  logic [NUM_CH-1:0] clr_fresh,
    input  logic              clr_pend,
    input  logic              clr_ovr,
    output logic [NUM_CH-1:0] fresh,
    output logic [NUM_CH-1:0] ovr,
    output logic              pend,
    output logic              govr
);

    typedef struct packed {
        logic [NUM_CH-1:0] fresh;
        logic [NUM_CH-1:0] ovr;
        logic              pend;
        logic              govr;
    } flag_t;

    flag_t             st_d, st_q;
    logic [NUM_CH-1:0] hit;

    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            hit[k] = accept && (ch == CH_W'(k));
        end
        // overrun tests use the registered flags, ahead of any clear this cycle
        st_d.fresh = (st_q.fresh & ~clr_fresh) | hit;
        st_d.ovr   = (clr_ovr ? '0 : st_q.ovr) | (hit & st_q.fresh);
        st_d.pend  = (st_q.pend & ~clr_pend) | accept;
        st_d.govr  = (st_q.govr & ~clr_ovr) | (accept & st_q.pend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fresh = st_q.fresh;
    assign ovr   = st_q.ovr;
    assign pend  = st_q.pend;
    assign govr  = st_q.govr;

endmodule

// File: rtl/adc_trk_port.sv
module adc_trk_port #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 10,
    localparam int STAT_W = 2 * NUM_CH + 2,
    localparam int ADDR_W = $clog2(NUM_CH + 2),
    localparam int RD_W   = (STAT_W > DATA_W) ? STAT_W : DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [NUM_CH*DATA_W-1:0] chan_flat,
    input  logic [DATA_W-1:0]        last_word,
    input  logic [STAT_W-1:0]        status,
    output logic [NUM_CH-1:0]        clr_fresh,
    output logic                     clr_pend,
    output logic                     clr_ovr,
    output logic [RD_W-1:0]          rd_data
);

    import adc_trk_pkg::*;

    typedef struct packed {
        logic [RD_W-1:0] rdata;
    } port_t;

    port_t             st_d, st_q;
    rd_sel_e           sel;
    logic [DATA_W-1:0] chan_word;

    always_comb begin
        sel = SEL_NONE;
        if (rd_en) begin
            if (rd_addr < ADDR_W'(NUM_CH)) begin
                sel = SEL_CHAN;
            end else if (rd_addr == ADDR_W'(NUM_CH)) begin
                sel = SEL_LAST;
            end else if (rd_addr == ADDR_W'(NUM_CH + 1)) begin
                sel = SEL_STAT;
            end
        end

        chan_word = '0;
        clr_fresh = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (rd_addr == ADDR_W'(k)) begin
                chan_word = chan_flat[k*DATA_W +: DATA_W];
                clr_fresh[k] = (sel == SEL_CHAN);
            end
        end
        clr_pend = (sel == SEL_LAST);
        clr_ovr  = (sel == SEL_STAT);

        st_d = st_q;
        if (rd_en) begin
            case (sel)
                SEL_CHAN: st_d.rdata = RD_W'(chan_word);
                SEL_LAST: st_d.rdata = RD_W'(last_word);
                SEL_STAT: st_d.rdata = RD_W'(status);
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;

endmodule

// File: rtl/adc_result_tracker.sv
module adc_result_tracker #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 10,
    localparam int CH_W   = adc_trk_pkg::chan_bits(NUM_CH),
    localparam int STAT_W = 2 * NUM_CH + 2,
    localparam int ADDR_W = $clog2(NUM_CH + 2),
    localparam int RD_W   = (STAT_W > DATA_W) ? STAT_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic              cnv_begin,
    input  logic [CH_W-1:0]   cnv_begin_ch,
    input  logic              cnv_done,
    input  logic [CH_W-1:0]   cnv_done_ch,
    input  logic [DATA_W-1:0] cnv_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data
);

    logic                     accept;
    logic [NUM_CH*DATA_W-1:0] chan_flat;
    logic [DATA_W-1:0]        last_word;
    logic [NUM_CH-1:0]        fresh_vec;
    logic [NUM_CH-1:0]        ovr_vec;
    logic                     pend_bit;
    logic                     govr_bit;
    logic [NUM_CH-1:0]        clr_fresh;
    logic                     clr_pend;
    logic                     clr_ovr;
    logic [STAT_W-1:0]        status;

    assign status = {govr_bit, pend_bit, ovr_vec, fresh_vec};

    adc_trk_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .chan_en      (chan_en),
        .cnv_begin    (cnv_begin),
        .cnv_begin_ch (cnv_begin_ch),
        .cnv_done     (cnv_done),
        .cnv_done_ch  (cnv_done_ch),
        .accept       (accept)
    );

    adc_trk_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .ch        (cnv_done_ch),
        .word      (cnv_data),
        .chan_flat (chan_flat),
        .last_word (last_word)
    );

    adc_trk_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .ch        (cnv_done_ch),
        .clr_fresh (clr_fresh),
        .clr_pend  (clr_pend),
        .clr_ovr   (clr_ovr),
        .fresh     (fresh_vec),
        .ovr       (ovr_vec),
        .pend      (pend_bit),
        .govr      (govr_bit)
    );

    adc_trk_port #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .chan_flat (chan_flat),
        .last_word (last_word),
        .status    (status),
        .clr_fresh (clr_fresh),
        .clr_pend  (clr_pend),
        .clr_ovr   (clr_ovr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/adc_trk_checker.sv
module adc_trk_checker #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 10,
    localparam int CH_W   = adc_trk_pkg::chan_bits(NUM_CH),
    localparam int STAT_W = 2 * NUM_CH + 2,
    localparam int ADDR_W = $clog2(NUM_CH + 2),
    localparam int RD_W   = (STAT_W > DATA_W) ? STAT_W : DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] chan_en,
    input logic              cnv_done,
    input logic [CH_W-1:0]   cnv_done_ch,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [RD_W-1:0]   rd_data,
    input logic              accept,
    input logic [NUM_CH-1:0] fresh,
    input logic [NUM_CH-1:0] ovr,
    input logic              pend,
    input logic              govr
);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        assert_fresh_set_R3: assert property (@(posedge clk) disable iff (rst)
            (accept && cnv_done_ch == CH_W'(k)) |=> fresh[k]);

        assert_ovr_set_R5: assert property (@(posedge clk) disable iff (rst)
            (accept && cnv_done_ch == CH_W'(k) && fresh[k]) |=> ovr[k]);
    end

    assert_pend_set_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> pend);

    assert_govr_set_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && pend) |=> govr);

    assert_last_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == ADDR_W'(NUM_CH) && !accept) |=> !pend);

    assert_status_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == ADDR_W'(NUM_CH + 1) && !accept) |=> (ovr == '0 && !govr));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && rd_en && rd_addr == ADDR_W'(cnv_done_ch)) |=> fresh[$past(cnv_done_ch)]);

    assert_discard_R9: assert property (@(posedge clk) disable iff (rst)
        (cnv_done && !chan_en[cnv_done_ch] && !rd_en)
        |=> ($stable(fresh) && $stable(ovr) && $stable(pend) && $stable(govr)));

    assert_no_accept_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        (cnv_done && !chan_en[cnv_done_ch]) |-> !accept);

    assert_out_of_map_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr > ADDR_W'(NUM_CH + 1)) |=> rd_data == '0);

endmodule

bind adc_result_tracker adc_trk_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .chan_en     (chan_en),
    .cnv_done    (cnv_done),
    .cnv_done_ch (cnv_done_ch),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .accept      (accept),
    .fresh       (fresh_vec),
    .ovr         (ovr_vec),
    .pend        (pend_bit),
    .govr        (govr_bit)
);

// File: tb/adc_result_tracker_test.sv
module adc_result_tracker_test;

    localparam int NUM_CH = 8;
    localparam int DATA_W = 10;
    localparam int CH_W   = 3;
    localparam int ADDR_W = 4;
    localparam int RD_W   = 18;
    localparam logic [ADDR_W-1:0] A_LAST = 4'd8;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd9;

    typedef struct {
        logic [RD_W-1:0] exp;
        string           tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] chan_en = '1;
    logic              cnv_begin = 1'b0;
    logic [CH_W-1:0]   cnv_begin_ch = '0;
    logic              cnv_done = 1'b0;
    logic [CH_W-1:0]   cnv_done_ch = '0;
    logic [DATA_W-1:0] cnv_data = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [RD_W-1:0]   rd_data;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    logic  rd_issued = 1'b0;
    bit    finished = 1'b0;

    always #10 clk = ~clk;

    adc_result_tracker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uut (
        .clk          (clk),
        .rst          (rst),
        .chan_en      (chan_en),
        .cnv_begin    (cnv_begin),
        .cnv_begin_ch (cnv_begin_ch),
        .cnv_done     (cnv_done),
        .cnv_done_ch  (cnv_done_ch),
        .cnv_data     (cnv_data),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data)
    );

    always @(posedge clk) rd_issued <= rd_en;

    // monitor: one expected item per read, compared away from the edge
    always @(negedge clk) begin
        if (rd_issued && !rst) begin
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: unexpected read data %h, expected none", rd_data);
            end else begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rd_data !== it.exp) begin
                    fails++;
                    $display("FAIL %s: rd_data=%h expected %h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        cnv_done  = 1'b0;
        cnv_begin = 1'b0;
        rd_en     = 1'b0;
    endtask

    task automatic put_rd(input logic [ADDR_W-1:0] a, input logic [RD_W-1:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        rd_en   = 1'b1;
        rd_addr = a;
    endtask

    task automatic put_done(input int ch, input logic [DATA_W-1:0] d);
        cnv_done    = 1'b1;
        cnv_done_ch = CH_W'(ch);
        cnv_data    = d;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [RD_W-1:0] e, input string tag);
        put_rd(a, e, tag);
        tick();
    endtask

    task automatic done(input int ch, input logic [DATA_W-1:0] d);
        put_done(ch, d);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(A_STAT, 18'h0, "R1 status after reset");
        rd(4'd3,   18'h0, "R1 channel 3 after reset");
        rd(A_LAST, 18'h0, "R1 last after reset");

        // R2 R3 R4 single result
        done(2, 10'h155);
        rd(A_STAT, 18'h10004, "R3 fresh2 and pend");
        rd(4'd2,   18'h00155, "R2 channel 2 data");
        rd(A_LAST, 18'h00155, "R2 last data");
        rd(A_STAT, 18'h0, "R4 reads cleared fresh2 and pend");

        // R5 R6 back-to-back on one channel, then R7 clearing
        done(5, 10'h0AA);
        done(5, 10'h3FF);
        rd(A_STAT, 18'h32020, "R5 R6 both overrun levels");
        rd(A_STAT, 18'h10020, "R7 status read cleared only overruns");
        rd(4'd5,   18'h003FF, "R2 channel 5 newest data");
        rd(A_LAST, 18'h003FF, "R2 last newest data");
        rd(A_STAT, 18'h0, "R4 all clear");

        // R4 selective channel clearing, R6 global overrun across channels
        done(0, 10'h001);
        done(1, 10'h002);
        rd(4'd0,   18'h00001, "R2 channel 0 data");
        rd(A_STAT, 18'h30002, "R4 only fresh0 cleared, R6 govr");
        rd(4'd1,   18'h00002, "R2 channel 1 data");
        rd(A_LAST, 18'h00002, "R2 last is channel 1");
        rd(A_STAT, 18'h0, "R7 govr already cleared");

        // R8 same-cycle channel read and completion
        done(4, 10'h111);
        put_rd(4'd4, 18'h00111, "R8 channel read returns old data");
        put_done(4, 10'h222);
        tick();
        rd(A_STAT, 18'h31010, "R8 set wins, overruns from pre-read flags");
        // R8 same-cycle status read and completion
        put_rd(A_STAT, 18'h10010, "R8 status read returns pre-cycle flags");
        put_done(6, 10'h333);
        tick();
        rd(A_STAT, 18'h30050, "R8 govr set wins over status clear");
        rd(4'd4,   18'h00222, "R2 channel 4 second data");
        rd(4'd6,   18'h00333, "R2 channel 6 data");
        // R8 same-cycle last read and completion
        put_rd(A_LAST, 18'h00333, "R8 last read returns old data");
        put_done(7, 10'h0F0);
        tick();
        rd(A_STAT, 18'h30080, "R8 pend set wins over last read");
        rd(4'd7,   18'h000F0, "R2 channel 7 data");
        rd(A_LAST, 18'h000F0, "R2 last is channel 7");
        rd(A_STAT, 18'h0, "R7 cleared again");

        // R9 disabled at completion
        chan_en[3] = 1'b0;
        done(3, 10'h123);
        chan_en[3] = 1'b1;
        rd(A_STAT, 18'h0, "R9 disabled completion sets no flag");
        rd(4'd3,   18'h0, "R9 disabled completion keeps channel 3");
        rd(A_LAST, 18'h000F0, "R9 disabled completion keeps last");
        // R9 disabled and re-enabled during a conversion
        cnv_begin = 1'b1; cnv_begin_ch = 3'd3;
        tick();
        chan_en[3] = 1'b0;
        tick();
        chan_en[3] = 1'b1;
        tick();
        done(3, 10'h124);
        rd(A_STAT, 18'h0, "R9 spoiled conversion sets no flag");
        rd(4'd3,   18'h0, "R9 spoiled conversion keeps channel 3");
        rd(A_LAST, 18'h000F0, "R9 spoiled conversion keeps last");
        // R9 clean conversion after a new start is accepted
        cnv_begin = 1'b1; cnv_begin_ch = 3'd3;
        tick();
        done(3, 10'h125);
        rd(A_STAT, 18'h10008, "R9 clean conversion accepted");
        rd(4'd3,   18'h00125, "R9 clean conversion data");
        rd(A_LAST, 18'h00125, "R9 clean conversion last");

        // R10 out-of-map reads
        rd(4'd12, 18'h0, "R10 address 12 reads zero");
        done(1, 10'h3AA);
        rd(4'd15, 18'h0, "R10 address 15 reads zero");
        rd(A_STAT, 18'h10002, "R10 out-of-map read had no side effect");
        rd(4'd1,   18'h003AA, "R2 channel 1 third data");

        repeat (3) tick();
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d reads unanswered, expected 0", sb.size());
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected end before 200000 cycles");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule